// File: doc/BRIEF.md
# Lithium-Cell Charger PWM Regulation Controller

This block is the digital regulation core of a single-cell lithium-polymer charger that switches a buck stage. A free-running counter and a duty register produce a fixed-frequency PWM. A synchronized battery-voltage comparator selects between constant-current and constant-voltage regulation. In constant-current mode the pulse train is blanked while the latest charge-current code is above a limit. In constant-voltage mode it is blanked while an upper-voltage comparator is high. Blanking decisions take effect only at period boundaries, so the switch never sees a shortened pulse.

Charging stops when the current tapers in constant-voltage mode, or when an over-temperature or over-voltage comparator trips. A stop is latched and persists until a synchronous reset or until the charger-removed input clears it. The current code enters on a valid/ready stream. A code is consumed on a clock where both `adc_valid` and `adc_ready` are high. `adc_ready` drops while charging is stopped. A source may hold valid across such stalls or withdraw it, and the code is not consumed until the handshake completes. The comparators arrive as asynchronous levels. Three limit registers are loaded through a write-only address/data port.

Top module: `chg_pwm_ctrl`

## Requirements
- R1: The PWM period is 16 clocks. Within a period the output is high while the period counter (0..15) is below the duty value, so the default duty of 10 gives 10 high clocks in every 16.
- R2: A write with `cfg_we` high stores `cfg_wdata` at the next clock edge. Address 0 holds the duty value (bits [3:0]), address 1 the current limit and address 2 the taper limit. Address 3 changes nothing. Reset loads duty 10, current limit 50 and taper limit 10.
- R3: `cv_mode` reports the mode input after a two-flop synchronizer. A change on the input appears after the second clock edge. 0 means constant-current and 1 means constant-voltage.
- R4: In constant-current mode, an accepted code strictly greater than the current limit marks over-current. A code equal to the limit does not. The blanking decision is taken on the clock where the counter is 15 and applies to the whole following period.
- R5: In constant-voltage mode, the synchronized upper-voltage input decides the blanking at the period boundary: high blanks the next period and low passes it. The current flag is ignored in this mode.
- R6: A code is accepted only on a clock where `adc_valid` and `adc_ready` are both high. `adc_ready` is low while `batt_full` or `fault` is set.
- R7: In constant-voltage mode, four consecutive accepted codes at or below the taper limit set `batt_full`. An accepted code above the limit, or any code accepted in constant-current mode, restarts the count. While `batt_full` is set the PWM output is low.
- R8: A synchronized high on the over-temperature or over-voltage input sets `fault`. While it is set the PWM output is low.
- R9: `batt_full` and `fault` stay set until reset or until the synchronized charger-removed input is high. Removal has priority over a simultaneous fault.
- R10: After reset, `pwm_out`, `batt_full`, `fault` and `cv_mode` are low and `adc_ready` is high. The first period after reset is blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| adc_valid | input | 1 | Current code valid |
| adc_ready | output | 1 | Current code accepted when high |
| adc_code | input | 8 | Charge-current code |
| mode_sel_async | input | 1 | Battery comparator, high selects constant-voltage |
| vlim_async | input | 1 | Upper-voltage comparator |
| otemp_async | input | 1 | Over-temperature comparator |
| ovolt_async | input | 1 | Over-voltage comparator |
| unplug_async | input | 1 | Charger removed, clears stop latches |
| pwm_out | output | 1 | Gated buck PWM |
| cv_mode | output | 1 | Regulation mode status |
| batt_full | output | 1 | Charge complete |
| fault | output | 1 | Temperature or voltage fault |

## Verification
The assertions assume the asynchronous comparator levels stay at a value for at least two clocks, so every change reaches the synchronized copies. They also assume the reset input is synchronous to the clock. The stimulus holds each comparator level for several clocks. It changes inputs only just after a falling edge and presents each current code for exactly one clock, so every handshake is a single clean transfer.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [1:0] {
    CFG_DUTY = 2'd0,
    CFG_ILIM = 2'd1,
    CFG_TAPER = 2'd2,
    CFG_NONE = 2'd3
  } cfg_addr_e;

  // Bit positions of the synchronized level bundle
  localparam int LV_MODE   = 0;
  localparam int LV_VLIM   = 1;
  localparam int LV_OTEMP  = 2;
  localparam int LV_OVOLT  = 3;
  localparam int LV_UNPLUG = 4;
  localparam int LV_COUNT  = 5;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/chg_cfg_regs.sv
module chg_cfg_regs
  import chg_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int CODE_W   = 8,
  parameter int DUTY_RST = 10,
  parameter int ILIM_RST = 50,
  parameter int TAPER_RST = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [CODE_W-1:0] wdata,
  output logic [CNT_W-1:0]  duty,
  output logic [CODE_W-1:0] ilim,
  output logic [CODE_W-1:0] taper
);
  always_ff @(posedge clk) begin
    if (rst) begin
      duty  <= CNT_W'(DUTY_RST);
      ilim  <= CODE_W'(ILIM_RST);
      taper <= CODE_W'(TAPER_RST);
    end else if (we) begin
      case (addr)
        CFG_DUTY:  duty  <= wdata[CNT_W-1:0];
        CFG_ILIM:  ilim  <= wdata;
        CFG_TAPER: taper <= wdata;
        default: ;
      endcase
    end
  end

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && addr == CFG_NONE) |=> $stable({duty, ilim, taper})); // R2
endmodule

// File: rtl/chg_pwm_gen.sv
module chg_pwm_gen #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_raw,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign wrap    = (cnt == CNT_LAST);
  assign pwm_raw = (cnt < duty);

  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_LAST) |=> (cnt == '0)); // R1
endmodule

// File: rtl/chg_supervisor.sv
module chg_supervisor #(
  parameter int CODE_W       = 8,
  parameter int TERM_SAMPLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cv_s,
  input  logic              vlim_s,
  input  logic              otemp_s,
  input  logic              ovolt_s,
  input  logic              unplug_s,
  input  logic              wrap,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [CODE_W-1:0] ilim,
  input  logic [CODE_W-1:0] taper,
  output logic              gate_en,
  output logic              full_q,
  output logic              fault_q,
  output logic              halted
);
  localparam int TC_W = $clog2(TERM_SAMPLES + 1);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(TERM_SAMPLES - 1);

  logic            over_i;
  logic [TC_W-1:0] tcnt;
  logic            take;
  logic            low_taper;

  assign halted    = full_q | fault_q;
  assign smp_ready = ~halted;
  assign take      = smp_valid & smp_ready;
  assign low_taper = cv_s & (smp_code <= taper);

  always_ff @(posedge clk) begin
    if (rst) begin
      over_i  <= 1'b0;
      gate_en <= 1'b0;
    end else begin
      if (take) over_i <= (smp_code > ilim);
      if (wrap) gate_en <= cv_s ? ~vlim_s : ~over_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || unplug_s) begin
      tcnt    <= '0;
      full_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (otemp_s || ovolt_s) fault_q <= 1'b1;
      if (take) begin
        if (low_taper) begin
          if (tcnt == TC_LAST) begin
            full_q <= 1'b1;
            tcnt   <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end else begin
          tcnt <= '0;
        end
      end
    end
  end

  AST_GATE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(gate_en)); // R4
  AST_FULL_NEEDS_CV: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> $past(cv_s)); // R7
  AST_TAPER_BOUND: assert property (@(posedge clk) disable iff (rst)
    tcnt < TC_W'(TERM_SAMPLES)); // R7
  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_q) |-> $past(otemp_s || ovolt_s)); // R8
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (full_q && !unplug_s) |=> full_q); // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !unplug_s) |=> fault_q); // R9
endmodule

// File: rtl/chg_pwm_ctrl.sv
module chg_pwm_ctrl
  import chg_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int CODE_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int TERM_SAMPLES = 4,
  parameter int DUTY_RST     = 10,
  parameter int ILIM_RST     = 50,
  parameter int TAPER_RST    = ILIM_RST / 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              adc_valid,
  output logic              adc_ready,
  input  logic [CODE_W-1:0] adc_code,
  input  logic              mode_sel_async,
  input  logic              vlim_async,
  input  logic              otemp_async,
  input  logic              ovolt_async,
  input  logic              unplug_async,
  output logic              pwm_out,
  output logic              cv_mode,
  output logic              batt_full,
  output logic              fault
);
  logic [LV_COUNT-1:0] lv_raw, lv_s;
  logic [CNT_W-1:0]    duty;
  logic [CODE_W-1:0]   ilim, taper;
  logic                pwm_raw, wrap, gate_en, halted;

  assign lv_raw[LV_MODE]   = mode_sel_async;
  assign lv_raw[LV_VLIM]   = vlim_async;
  assign lv_raw[LV_OTEMP]  = otemp_async;
  assign lv_raw[LV_OVOLT]  = ovolt_async;
  assign lv_raw[LV_UNPLUG] = unplug_async;

  chg_sync #(.W(LV_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(lv_raw), .q(lv_s)
  );

  chg_cfg_regs #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .DUTY_RST(DUTY_RST),
    .ILIM_RST(ILIM_RST), .TAPER_RST(TAPER_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .duty(duty), .ilim(ilim), .taper(taper)
  );

  chg_pwm_gen #(.CNT_W(CNT_W)) u_pwm (
    .clk(clk), .rst(rst), .duty(duty), .pwm_raw(pwm_raw), .wrap(wrap)
  );

  chg_supervisor #(.CODE_W(CODE_W), .TERM_SAMPLES(TERM_SAMPLES)) u_sup (
    .clk(clk), .rst(rst),
    .cv_s(lv_s[LV_MODE]), .vlim_s(lv_s[LV_VLIM]),
    .otemp_s(lv_s[LV_OTEMP]), .ovolt_s(lv_s[LV_OVOLT]),
    .unplug_s(lv_s[LV_UNPLUG]), .wrap(wrap),
    .smp_valid(adc_valid), .smp_ready(adc_ready), .smp_code(adc_code),
    .ilim(ilim), .taper(taper),
    .gate_en(gate_en), .full_q(batt_full), .fault_q(fault), .halted(halted)
  );

  assign pwm_out = pwm_raw & gate_en & ~halted;
  assign cv_mode = lv_s[LV_MODE];
endmodule

// File: tb/tb_chg_pwm_ctrl.sv
`timescale 1ns/1ps
module tb_chg_pwm_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic adc_valid = 1'b0;
  logic adc_ready;
  logic [7:0] adc_code = 8'd0;
  logic mode_sel_async = 1'b0, vlim_async = 1'b0, otemp_async = 1'b0;
  logic ovolt_async = 1'b0, unplug_async = 1'b0;
  logic pwm_out, cv_mode, batt_full, fault;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  chg_pwm_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .adc_valid(adc_valid), .adc_ready(adc_ready), .adc_code(adc_code),
    .mode_sel_async(mode_sel_async), .vlim_async(vlim_async),
    .otemp_async(otemp_async), .ovolt_async(ovolt_async), .unplug_async(unplug_async),
    .pwm_out(pwm_out), .cv_mode(cv_mode), .batt_full(batt_full), .fault(fault)
  );

  // Behavioural reference model
  int m_cnt, m_duty, m_ilim, m_taper, m_tcnt;
  bit m_over, m_gate, m_full, m_flt;
  bit [4:0] m_s1, m_s2;
  bit m_take, n_over, n_gate, n_full, n_flt;
  int n_tcnt;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_duty = 10; m_ilim = 50; m_taper = 10; m_tcnt = 0;
      m_over = 0; m_gate = 0; m_full = 0; m_flt = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_take = adc_valid && !(m_full || m_flt);
      n_over = m_take ? (int'(adc_code) > m_ilim) : m_over;
      n_gate = m_gate;
      if (m_cnt == 15) n_gate = m_s2[0] ? !m_s2[1] : !m_over;
      n_full = m_full; n_flt = m_flt; n_tcnt = m_tcnt;
      if (m_s2[4]) begin
        n_full = 0; n_flt = 0; n_tcnt = 0;
      end else begin
        if (m_s2[2] || m_s2[3]) n_flt = 1;
        if (m_take) begin
          if (m_s2[0] && int'(adc_code) <= m_taper) begin
            if (m_tcnt == 3) begin n_full = 1; n_tcnt = 0; end
            else n_tcnt = m_tcnt + 1;
          end else n_tcnt = 0;
        end
      end
      if (cfg_we) begin
        if (cfg_addr == 2'd0) m_duty = int'(cfg_wdata[3:0]);
        else if (cfg_addr == 2'd1) m_ilim = int'(cfg_wdata);
        else if (cfg_addr == 2'd2) m_taper = int'(cfg_wdata);
      end
      m_over = n_over; m_gate = n_gate; m_full = n_full; m_flt = n_flt; m_tcnt = n_tcnt;
      m_s2 = m_s1;
      m_s1 = {unplug_async, ovolt_async, otemp_async, vlim_async, mode_sel_async};
      m_cnt = (m_cnt + 1) % 16;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R1", "pwm_out vs model", int'(pwm_out),
          int'((m_cnt < m_duty) && m_gate && !(m_full || m_flt)));
      chk("R3", "cv_mode vs model", int'(cv_mode), int'(m_s2[0]));
      chk("R7", "batt_full vs model", int'(batt_full), int'(m_full));
      chk("R8", "fault vs model", int'(fault), int'(m_flt));
      chk("R6", "adc_ready vs model", int'(adc_ready), int'(!(m_full || m_flt)));
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL R1 watchdog expired actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    idle(1);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    idle(1);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] code);
    idle(1);
    adc_code = code; adc_valid = 1'b1;
    idle(1);
    adc_valid = 1'b0;
  endtask

  task automatic highs(output int n);
    n = 0;
    repeat (16) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
    #1;
  endtask

  int h;

  initial begin
    idle(3);
    chk("R10", "pwm after reset", int'(pwm_out), 0);
    chk("R10", "full after reset", int'(batt_full), 0);
    chk("R10", "fault after reset", int'(fault), 0);
    chk("R10", "cv_mode after reset", int'(cv_mode), 0);
    chk("R10", "ready after reset", int'(adc_ready), 1);
    rst = 1'b0;
    idle(1);
    chk("R10", "first period blanked", int'(pwm_out), 0);

    idle(24); highs(h); chk("R1", "default duty highs", h, 10);
    wr(2'd0, 8'd4); idle(20); highs(h); chk("R2", "duty 4 highs", h, 4);
    wr(2'd3, 8'hFF); idle(20); highs(h); chk("R2", "addr 3 ignored", h, 4);
    wr(2'd0, 8'd10);

    send(8'd60); idle(40); highs(h); chk("R4", "over limit blanks", h, 0);
    send(8'd50); idle(40); highs(h); chk("R4", "equal limit passes", h, 10);
    wr(2'd1, 8'd70); send(8'd60); idle(40); highs(h); chk("R4", "raised limit passes", h, 10);

    idle(1); mode_sel_async = 1'b1;
    idle(1); chk("R3", "cv_mode after one edge", int'(cv_mode), 0);
    idle(1); chk("R3", "cv_mode after two edges", int'(cv_mode), 1);

    send(8'd200); idle(40); highs(h); chk("R5", "current ignored in CV", h, 10);
    idle(1); vlim_async = 1'b1; idle(40); highs(h); chk("R5", "vlim blanks", h, 0);
    idle(1); vlim_async = 1'b0; idle(40); highs(h); chk("R5", "vlim low passes", h, 10);

    repeat (3) send(8'd5);
    send(8'd50);
    repeat (3) send(8'd5);
    chk("R7", "interrupted run not full", int'(batt_full), 0);
    send(8'd10);
    chk("R7", "fourth low code sets full", int'(batt_full), 1);
    highs(h); chk("R7", "no pwm when full", h, 0);
    chk("R6", "ready low when full", int'(adc_ready), 0);
    send(8'd0); idle(30);
    chk("R9", "full persists", int'(batt_full), 1);

    idle(1); unplug_async = 1'b1; idle(3); unplug_async = 1'b0; idle(4);
    chk("R9", "removal clears full", int'(batt_full), 0);
    chk("R6", "ready back after clear", int'(adc_ready), 1);

    idle(1); mode_sel_async = 1'b0; idle(4);
    repeat (5) send(8'd0);
    chk("R7", "no taper stop in CC", int'(batt_full), 0);

    idle(1); otemp_async = 1'b1; idle(3); otemp_async = 1'b0; idle(4);
    chk("R8", "over-temp sets fault", int'(fault), 1);
    highs(h); chk("R8", "no pwm on fault", h, 0);
    idle(20); chk("R9", "fault persists", int'(fault), 1);
    idle(1); unplug_async = 1'b1; idle(3); unplug_async = 1'b0; idle(4);
    chk("R9", "removal clears fault", int'(fault), 0);

    idle(1); ovolt_async = 1'b1; unplug_async = 1'b1; idle(6);
    chk("R9", "removal wins over fault", int'(fault), 0);
    unplug_async = 1'b0; idle(4);
    chk("R8", "over-voltage sets fault", int'(fault), 1);
    ovolt_async = 1'b0; unplug_async = 1'b1; idle(4); unplug_async = 1'b0; idle(4);

    wr(2'd0, 8'd3);
    rst = 1'b1; idle(2); rst = 1'b0;
    idle(40); highs(h); chk("R2", "reset restores duty", h, 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule